// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is a serial test access port for board-level interconnect testing. An external tester clocks it through `tck_i`, steers it with `tms_i` and feeds serial data on `tdi_i`; results come back on `tdo_o`. Inside, a 16-state controller, a 4-bit instruction register and a choice of data registers decide what sits between `tdi_i` and `tdo_o`. The data registers are a one-bit bypass cell, a 32-bit identification word, a boundary chain of three cells per I/O pin, and a serial path out to a debug/programming engine.

On the pin side, the block sits between the core and the pads. It passes the core's output value and output enable through unchanged, or replaces them with values from the boundary update latches, or forces every output enable low.

Two inputs gate the interface. A permanent enable must be high and a software disable must be low. If either condition fails, the controller is held in its reset state, the pins follow the core and `tdo_o` is never enabled.

Top module: `jtag_bscan_ctrl`

## Requirements
- R1: After `rst_ni` is asserted, and whenever the controller sits in Test-Logic-Reset, the active instruction is IDCODE. The next data scan then shifts out the 32-bit word {version[3:0], part[15:0], maker[10:0], 1'b1}, least significant bit first.
- R2: The controller follows the standard 16-state diagram on rising `tck_i`. Five consecutive rising edges with `tms_i` high reach Test-Logic-Reset from any state, which cancels any pin override.
- R3: The instruction register is 4 bits wide, shifts least significant bit first and captures 4'b0001. The opcodes are: 0000 drive-pins, 0001 sample/preload, 0011 IDCODE, 0100 clamp, 0101 float, 0111 debug, 1111 BYPASS.
- R4: BYPASS and every undefined opcode select a one-bit register that captures 0. The scanned-out stream is therefore `tdi_i` delayed by one `tck_i`, with a leading 0.
- R5: Sample/preload selects the boundary chain without changing any pin. For pin k, Capture-DR loads bit 3k from `pad_in_i[k]`, bit 3k+1 from `core_out_i[k]` and bit 3k+2 from `core_oe_i[k]`. Bit 0 leaves first. Update-DR copies the chain into the update latches.
- R6: Drive-pins puts update-latch bit 3k+1 on `pad_out_o[k]` and bit 3k+2 on `pad_oe_o[k]` from the Update-IR that loads it. It uses the same boundary chain and capture layout as R5.
- R7: Clamp drives the pins from the update latches in the same way, with the bypass cell as the scan path.
- R8: Float forces every `pad_oe_o` bit low, with the bypass cell as the scan path.
- R9: Debug routes `dbg_tdo_i` to the scan output and raises `dbg_sel_o`. During its scans it also raises `dbg_capture_o`, `dbg_shift_o` and `dbg_update_o` in the matching states. The pins keep following the core.
- R10: When `jtag_en_i` is low or `jtag_dis_i` is high, the controller is held in reset, the pins follow the core and `tdo_oe_o` stays low.
- R11: `tdo_o` changes only on falling `tck_i`. `tdo_oe_o` is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| tms_i | input | 1 | Mode select, sampled on rising tck_i |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, updated on falling tck_i |
| tdo_oe_o | output | 1 | Enable for tdo_o |
| jtag_en_i | input | 1 | Permanent enable, high to allow the interface |
| jtag_dis_i | input | 1 | Software disable, high to block the interface |
| core_out_i | input | NUM_PINS | Core output value per pin |
| core_oe_i | input | NUM_PINS | Core output enable per pin |
| pad_in_i | input | NUM_PINS | Value seen at each pad |
| pad_out_o | output | NUM_PINS | Value driven to each pad |
| pad_oe_o | output | NUM_PINS | Drive enable for each pad |
| dbg_sel_o | output | 1 | Debug register is the current scan path |
| dbg_capture_o | output | 1 | Debug register capture strobe |
| dbg_shift_o | output | 1 | Debug register shift strobe |
| dbg_update_o | output | 1 | Debug register update strobe |
| dbg_tdo_i | input | 1 | Serial output of the debug register |

## Verification
Each scan bit is due at `tdo_o` on the falling edge after the rising edge that moved the chain, so the bench drives `tms_i`/`tdi_i` just after a falling edge and reads `tdo_o` half a period later, before the next rising edge. It also re-reads one step after the rising edge to show the output did not move there. Instruction and boundary updates are latched on the falling edge spent in the Update state, and the controller reaches Run-Test/Idle at the next rising edge. Pin checks are therefore made only after each scan task returns from that edge. Expected scan words are queued before each scan and popped when its captured stream is complete.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;
  localparam int unsigned IR_W = 4;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0011;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0100;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0101;
  localparam logic [IR_W-1:0] OP_DEBUG   = 4'b0111;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      TLR:     state_d = tms_i ? TLR    : RTI;
      RTI:     state_d = tms_i ? SEL_DR : RTI;
      SEL_DR:  state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:   state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR:  state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR:  state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR:  state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR:  state_d = tms_i ? SEL_DR : RTI;
      SEL_IR:  state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:   state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR:  state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR:  state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR:  state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR:  state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // consecutive TMS-high edges, for the reset-escape check
  logic [2:0] hi_cnt_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)          hi_cnt_q <= '0;
    else if (!tms_i)      hi_cnt_q <= '0;
    else if (hi_cnt_q < 3'd5) hi_cnt_q <= hi_cnt_q + 3'd1;
  end

  p_tms_escape_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (hi_cnt_q == 3'd5) |-> (state_q == TLR));
endmodule

// File: rtl/jtag_ir_dec.sv
module jtag_ir_dec
  import jtag_bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  output logic       ir_tdo_o,
  output logic       sel_byp_o,
  output logic       sel_id_o,
  output logic       sel_bsr_o,
  output logic       sel_dbg_o,
  output logic       pin_drive_o,
  output logic       pin_hiz_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                sr_q <= '0;
    else if (state_i == CAP_IR) sr_q <= IR_CAPTURE;
    else if (state_i == SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  // instruction changes on the falling edge spent in Update-IR / TLR
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                ir_q <= OP_IDCODE;
    else if (state_i == TLR)    ir_q <= OP_IDCODE;
    else if (state_i == UPD_IR) ir_q <= sr_q;
  end

  assign ir_tdo_o = sr_q[0];

  always_comb begin
    sel_byp_o = 1'b0; sel_id_o = 1'b0; sel_bsr_o = 1'b0; sel_dbg_o = 1'b0;
    pin_drive_o = 1'b0; pin_hiz_o = 1'b0;
    unique case (ir_q)
      OP_EXTEST: begin sel_bsr_o = 1'b1; pin_drive_o = 1'b1; end
      OP_SAMPLE: sel_bsr_o = 1'b1;
      OP_IDCODE: sel_id_o  = 1'b1;
      OP_CLAMP:  begin sel_byp_o = 1'b1; pin_drive_o = 1'b1; end
      OP_HIGHZ:  begin sel_byp_o = 1'b1; pin_hiz_o = 1'b1; end
      OP_DEBUG:  sel_dbg_o = 1'b1;
      default:   sel_byp_o = 1'b1;
    endcase
  end

  p_tlr_idcode_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TLR) |-> (ir_q == OP_IDCODE));
  p_sel_onehot_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $countones({sel_byp_o, sel_id_o, sel_bsr_o, sel_dbg_o}) == 1);
endmodule

// File: rtl/jtag_bsr.sv
module jtag_bsr
  import jtag_bscan_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  tap_state_e          state_i,
  input  logic                sel_i,
  input  logic                tdi_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] core_out_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  output logic                sr_tdo_o,
  output logic [NUM_PINS-1:0] upd_out_o,
  output logic [NUM_PINS-1:0] upd_oe_o
);
  localparam int unsigned CELLS = 3;
  localparam int unsigned W     = CELLS * NUM_PINS;

  logic [W-1:0] cap, sr_q, upd_q;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    assign cap[CELLS*k]     = pad_in_i[k];
    assign cap[CELLS*k + 1] = core_out_i[k];
    assign cap[CELLS*k + 2] = core_oe_i[k];
    assign upd_out_o[k]     = upd_q[CELLS*k + 1];
    assign upd_oe_o[k]      = upd_q[CELLS*k + 2];
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                         sr_q <= '0;
    else if (sel_i && state_i == CAP_DR) sr_q <= cap;
    else if (sel_i && state_i == SH_DR)  sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                         upd_q <= '0;
    else if (sel_i && state_i == UPD_DR) upd_q <= sr_q;
  end

  assign sr_tdo_o = sr_q[0];
endmodule

// File: rtl/jtag_bscan_ctrl.sv
module jtag_bscan_ctrl
  import jtag_bscan_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 4,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'hB5A3,
  parameter logic [10:0] ID_MFR     = 11'h0AB
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tms_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  output logic                tdo_oe_o,
  input  logic                jtag_en_i,
  input  logic                jtag_dis_i,
  input  logic [NUM_PINS-1:0] core_out_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                dbg_sel_o,
  output logic                dbg_capture_o,
  output logic                dbg_shift_o,
  output logic                dbg_update_o,
  input  logic                dbg_tdo_i
);
  localparam int unsigned ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  logic       tap_rst_n;
  tap_state_e state;
  logic       ir_tdo, bsr_tdo;
  logic       sel_byp, sel_id, sel_bsr, sel_dbg, pin_drive, pin_hiz;
  logic [NUM_PINS-1:0] upd_out, upd_oe;

  // both enables fold into the TAP reset
  assign tap_rst_n = rst_ni & jtag_en_i & ~jtag_dis_i;

  jtag_tap_fsm u_fsm (
    .tck_i, .rst_ni(tap_rst_n), .tms_i, .state_o(state)
  );

  jtag_ir_dec u_ir (
    .tck_i, .rst_ni(tap_rst_n), .state_i(state), .tdi_i,
    .ir_tdo_o(ir_tdo), .sel_byp_o(sel_byp), .sel_id_o(sel_id),
    .sel_bsr_o(sel_bsr), .sel_dbg_o(sel_dbg),
    .pin_drive_o(pin_drive), .pin_hiz_o(pin_hiz)
  );

  jtag_bsr #(.NUM_PINS(NUM_PINS)) u_bsr (
    .tck_i, .rst_ni(tap_rst_n), .state_i(state), .sel_i(sel_bsr), .tdi_i,
    .pad_in_i, .core_out_i, .core_oe_i,
    .sr_tdo_o(bsr_tdo), .upd_out_o(upd_out), .upd_oe_o(upd_oe)
  );

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck_i or negedge tap_rst_n) begin
    if (!tap_rst_n)                        byp_q <= 1'b0;
    else if (sel_byp && state == CAP_DR)   byp_q <= 1'b0;
    else if (sel_byp && state == SH_DR)    byp_q <= tdi_i;
  end

  always_ff @(posedge tck_i or negedge tap_rst_n) begin
    if (!tap_rst_n)                        id_q <= '0;
    else if (sel_id && state == CAP_DR)    id_q <= ID_WORD;
    else if (sel_id && state == SH_DR)     id_q <= {tdi_i, id_q[ID_W-1:1]};
  end

  logic dr_tdo;
  always_comb begin
    if (sel_bsr)     dr_tdo = bsr_tdo;
    else if (sel_id) dr_tdo = id_q[0];
    else if (sel_dbg) dr_tdo = dbg_tdo_i;
    else             dr_tdo = byp_q;
  end

  logic tdo_q, tdo_oe_q;
  always_ff @(negedge tck_i or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_oe_q <= (state == SH_IR) || (state == SH_DR);
      if (state == SH_IR)      tdo_q <= ir_tdo;
      else if (state == SH_DR) tdo_q <= dr_tdo;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = tdo_oe_q;

  always_comb begin
    if (pin_hiz) begin
      pad_out_o = core_out_i;
      pad_oe_o  = '0;
    end else if (pin_drive) begin
      pad_out_o = upd_out;
      pad_oe_o  = upd_oe;
    end else begin
      pad_out_o = core_out_i;
      pad_oe_o  = core_oe_i;
    end
  end

  assign dbg_sel_o     = sel_dbg;
  assign dbg_capture_o = sel_dbg && (state == CAP_DR);
  assign dbg_shift_o   = sel_dbg && (state == SH_DR);
  assign dbg_update_o  = sel_dbg && (state == UPD_DR);

  p_tdo_oe_r11: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    tdo_oe_o == ((state == SH_IR) || (state == SH_DR)));
  p_bypass_zero_r4: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    (sel_byp && state == CAP_DR) |=> (byp_q == 1'b0));
  p_drive_hold_r6: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    (pin_drive && !(state inside {UPD_DR, UPD_IR, TLR})) |-> $stable(upd_out));
endmodule

// File: tb/jtag_bscan_ctrl_tb.sv
module jtag_bscan_ctrl_tb;
  localparam int PERIOD = 20;
  localparam int NP     = 4;
  localparam logic [31:0] ID_EXP = {4'h1, 16'hB5A3, 11'h0AB, 1'b1};

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic en = 1'b1, dis = 1'b0, dbg_tdo = 1'b1;
  logic [NP-1:0] core_out = 4'b0110, core_oe = 4'b1100, pad_in = 4'b1010;
  logic tdo, tdo_oe, dbg_sel, dbg_cap, dbg_sh, dbg_upd;
  logic [NP-1:0] pad_out, pad_oe;

  always #(PERIOD/2) tck = ~tck;

  jtag_bscan_ctrl #(.NUM_PINS(NP)) u_dut (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(tdo_oe), .jtag_en_i(en), .jtag_dis_i(dis),
    .core_out_i(core_out), .core_oe_i(core_oe), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .dbg_sel_o(dbg_sel), .dbg_capture_o(dbg_cap), .dbg_shift_o(dbg_sh),
    .dbg_update_o(dbg_upd), .dbg_tdo_i(dbg_tdo)
  );

  typedef struct { string tag; logic [63:0] v; } exp_t;
  exp_t sb_q[$];
  int n_chk = 0, n_bad = 0;
  int oe_in_shift_low = 0, oe_seen = 0, rise_moves = 0, dbg_sh_seen = 0;
  bit done = 0;

  task automatic expect_v(input string tag, input logic [63:0] v);
    exp_t e; e.tag = tag; e.v = v; sb_q.push_back(e);
  endtask

  task automatic compare(input logic [63:0] act);
    exp_t e;
    e = sb_q.pop_front();
    n_chk++;
    if (act !== e.v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", e.tag, act, e.v);
    end
  endtask

  task automatic step(input logic m, input logic d, input bit shifting, output logic q);
    @(negedge tck); #1;
    tms = m; tdi = d;
    #(PERIOD/2 - 3);
    q = tdo;
    if (tdo_oe) oe_seen++;
    if (shifting && !tdo_oe) oe_in_shift_low++;
    if (dbg_sh) dbg_sh_seen++;
    @(posedge tck); #1;
    if (shifting && tdo !== q) rise_moves++;
  endtask

  task automatic goto_idle();
    logic q;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 0, q);
    step(1'b0, 1'b0, 0, q);
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    logic q;
    step(1, 0, 0, q); step(1, 0, 0, q); step(0, 0, 0, q); step(0, 0, 0, q);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], 1, q);
      cap[i] = q;
    end
    step(1, 0, 0, q); step(0, 0, 0, q);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic q;
    dout = '0;
    step(1, 0, 0, q); step(0, 0, 0, q); step(0, 0, 0, q);
    for (int i = 0; i < n; i++) begin
      step(i == n-1, din[i], 1, q);
      dout[i] = q;
    end
    step(1, 0, 0, q); step(0, 0, 0, q);
  endtask

  function automatic logic [63:0] cap_vec();
    logic [63:0] v = '0;
    for (int k = 0; k < NP; k++) begin
      v[3*k] = pad_in[k]; v[3*k+1] = core_out[k]; v[3*k+2] = core_oe[k];
    end
    return v;
  endfunction

  function automatic logic [7:0] pins_of(input logic [63:0] p);
    logic [7:0] r = '0;
    for (int k = 0; k < NP; k++) begin
      r[k] = p[3*k+2]; r[k+4] = p[3*k+1];
    end
    return r; // {out, oe}
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] ircap;
    logic [63:0] dout;
    logic [63:0] pre1, pre2;
    pre1 = 64'hA5C; pre2 = 64'h3F0;
    #(PERIOD*2 + 3);
    // reset state
    expect_v("R10 reset pins", {56'd0, core_out, core_oe});
    compare({56'd0, pad_out, pad_oe});
    expect_v("R11 tdo_oe at reset", 64'd0);
    compare({63'd0, tdo_oe});
    rst_n = 1'b1;
    begin logic q; step(0, 0, 0, q); end

    // R1: first DR scan after reset yields ID
    expect_v("R1 idcode", {32'd0, ID_EXP});
    scan_dr(32, 64'd0, dout); compare(dout);

    // R3 capture pattern, R4 bypass
    scan_ir(4'b1111, ircap);
    expect_v("R3 ir capture", 64'b0001); compare({60'd0, ircap});
    expect_v("R4 bypass delay", {56'd0, 8'hA5 << 1});
    scan_dr(8, 64'hA5, dout); compare(dout);

    // R5 sample/preload
    scan_ir(4'b0001, ircap);
    expect_v("R5 capture layout", cap_vec());
    scan_dr(3*NP, pre1, dout); compare(dout);
    expect_v("R5 pins untouched", {56'd0, core_out, core_oe});
    compare({56'd0, pad_out, pad_oe});

    // R6 drive-pins
    scan_ir(4'b0000, ircap);
    expect_v("R6 pins from latches", {56'd0, pins_of(pre1)});
    compare({56'd0, pad_out, pad_oe});
    pad_in = 4'b0011;
    expect_v("R6 pad sampling", cap_vec());
    scan_dr(3*NP, pre2, dout); compare(dout);
    expect_v("R6 new latches", {56'd0, pins_of(pre2)});
    compare({56'd0, pad_out, pad_oe});

    // R7 clamp
    scan_ir(4'b0100, ircap);
    expect_v("R7 clamp pins", {56'd0, pins_of(pre2)});
    compare({56'd0, pad_out, pad_oe});
    expect_v("R7 clamp bypass", {56'd0, 8'h3C << 1});
    scan_dr(8, 64'h3C, dout); compare(dout);

    // R8 float
    scan_ir(4'b0101, ircap);
    expect_v("R8 oe forced low", 64'd0); compare({60'd0, pad_oe});
    expect_v("R8 float bypass", {56'd0, 8'h96 << 1});
    scan_dr(8, 64'h96, dout); compare(dout);

    // R9 debug path
    scan_ir(4'b0111, ircap);
    expect_v("R9 debug select and pins", {55'd0, dbg_sel, core_out, core_oe} | 64'd0);
    compare({55'd0, 1'b1, pad_out, pad_oe});
    dbg_sh_seen = 0;
    expect_v("R9 debug data", 64'h3F);
    scan_dr(6, 64'h0, dout); compare(dout);
    expect_v("R9 debug shift strobe", 64'd6); compare(64'(dbg_sh_seen));

    // R4 undefined opcode
    scan_ir(4'b1010, ircap);
    expect_v("R4 undefined acts as bypass", {56'd0, 8'h5B << 1});
    scan_dr(8, 64'h5B, dout); compare(dout);

    // R2 TMS escape cancels drive
    scan_ir(4'b0000, ircap);
    goto_idle();
    expect_v("R2 tms reset pins", {56'd0, core_out, core_oe});
    compare({56'd0, pad_out, pad_oe});
    expect_v("R2 idcode after escape", {32'd0, ID_EXP});
    scan_dr(32, 64'd0, dout); compare(dout);

    // R11 output timing
    expect_v("R11 tdo steady at rising edge", 64'd0); compare(64'(rise_moves));
    expect_v("R11 oe during shift", 64'd0); compare(64'(oe_in_shift_low));
    #1;
    expect_v("R11 oe idle", 64'd0); compare({63'd0, tdo_oe});

    // R10 enable gating
    scan_ir(4'b0101, ircap);
    dis = 1'b1; #1;
    expect_v("R10 disable releases pins", {56'd0, core_out, core_oe});
    compare({56'd0, pad_out, pad_oe});
    oe_seen = 0;
    scan_ir(4'b0000, ircap);
    scan_dr(12, 64'hFFF, dout);
    expect_v("R10 tdo never enabled", 64'd0); compare(64'(oe_seen));
    expect_v("R10 pins still core", {56'd0, core_out, core_oe});
    compare({56'd0, pad_out, pad_oe});
    dis = 1'b0; en = 1'b0;
    scan_ir(4'b0101, ircap);
    expect_v("R10 fuse low blocks", {56'd0, core_out, core_oe});
    compare({56'd0, pad_out, pad_oe});
    en = 1'b1;
    begin logic q; step(0, 0, 0, q); end

    // R1 asynchronous reset mid-instruction
    scan_ir(4'b0101, ircap);
    rst_n = 1'b0; #2;
    expect_v("R1 async reset pins", {56'd0, core_out, core_oe});
    compare({56'd0, pad_out, pad_oe});
    rst_n = 1'b1;
    begin logic q; step(0, 0, 0, q); end
    expect_v("R1 idcode after reset", {32'd0, ID_EXP});
    scan_dr(32, 64'd0, dout); compare(dout);

    finish_run();
  end
endmodule